// File: doc/BRIEF.md
# Two-Word 8-Bit RISC Instruction Decoder

This block turns a stream of 16-bit instruction words for a small 8-bit RISC core into decoded fields. Each output carries an operation code, a destination register index, a source register index, a 22-bit immediate and a 3-bit bit index. Words arrive one per accepted beat. Most instructions are one word long. Their result appears on the cycle after the beat.

Four instructions carry a second word: the long jump, the long call, the direct load and the direct store. The decoder keeps the first of these words and emits nothing until the next accepted beat. It then emits one result that combines both words.

Compressed register fields are widened to full 5-bit register indices, in the range each instruction family is limited to. Words that match no known encoding come out flagged as illegal. Execution, flags, memory and the program counter are handled elsewhere.

Top module: `insn_word_decoder`

## Requirements
- R1: A synchronous active-high `rst` clears any held first word and drops `out_valid`. `in_ready` is low while `rst` is high and high otherwise. The first beat after reset is decoded as a fresh instruction, even if a second word was awaited before reset.
- R2: An accepted beat (`in_valid` and `in_ready` high) that completes an instruction sets `out_valid` high for exactly the next cycle, with the fields registered alongside it. Fields that an operation does not use read zero.
- R3: For register-pair forms `rd` = word[8:4] and `rr` = {word[9], word[3:0]}. For example, ADD `0000 11rd dddd rrrr` gives op 1.
- R4: The 8-bit-immediate forms map `rd` = 16 + word[7:4] and give `imm` = {word[11:8], word[3:0]}. LDI `1110 KKKK dddd KKKK` is op 2 and SUBI `0101 ...` is op 21.
- R5: The word add `1001 0110 KKdd KKKK` (op 3) and the word subtract `1001 0111 ...` (op 22) give `rd` = 24 + 2·word[5:4] and `imm` = {word[7:6], word[3:0]}.
- R6: The register-pair move `0000 0001 dddd rrrr` (op 4) gives `rd` = 2·word[7:4] and `rr` = 2·word[3:0]. The signed multiply `0000 0010 dddd rrrr` (op 5) gives `rd` = 16 + word[7:4] and `rr` = 16 + word[3:0].
- R7: In `0000 0011 a ddd b rrr`, `rd` = 16 + word[6:4] and `rr` = 16 + word[2:0]. The pair {a,b} picks the operation: 00 → op 24 (signed-by-unsigned multiply), 01 → op 23 (fractional), 10 → op 25 (fractional signed), 11 → op 6 (fractional signed-by-unsigned).
- R8: The long jump `1001 010k kkkk 110k` (op 7) and the long call `1001 010k kkkk 111k` (op 8) take a second word. The result has `imm` = {first[8:4], first[0], second word}, and `rd`, `rr` and `bit` are zero.
- R9: The direct load `1001 000d dddd 0000` (op 9) and the direct store `1001 001d dddd 0000` (op 10) take a second word. The result has `rd` = first[8:4] and `imm` = the second word, zero-extended. A second word is never decoded by itself, even when it is 0x0000.
- R10: While a second word is awaited, `out_valid` stays low for any number of cycles with `in_valid` low, and the held first word is unchanged. Exactly one result follows the second accepted beat.
- R11: In the displacement forms `10q0 qqsd dddd yqqq`, `rd` = word[8:4] and `imm` = {word[13], word[11:10], word[2:0]}. The pair (s,y) picks the operation: load Y → op 11, load Z → op 12, store Y → op 13, store Z → op 14.
- R12: The relative jump `1100 kkkk kkkk kkkk` (op 15) gives `imm` = word[11:0], sign-extended to 22 bits. The branch-if-set form `1111 00kk kkkk ksss` (op 16) gives `imm` = word[9:3], sign-extended, and `bit` = word[2:0].
- R13: Fixed words must match in full: 0x0000 → op 0, 0x9508 → op 17, 0x9518 → op 18, 0x9409 → op 19, 0x9588 → op 20. A one-bit variant that no encoding covers, such as 0x9528, is illegal.
- R14: A word that no encoding covers gives `out_illegal` = 1 with op 0 and all other fields zero. It never starts a two-word sequence, so the next word is decoded by itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Instruction word present |
| in_ready | output | 1 | Decoder accepts a word this cycle |
| in_word | input | 16 | Instruction word |
| out_valid | output | 1 | Decoded result present |
| out_op | output | 7 | Operation code |
| out_rd | output | 5 | Destination register index |
| out_rr | output | 5 | Source register index |
| out_imm | output | 22 | Immediate, address or displacement |
| out_bit | output | 3 | Bit index |
| out_illegal | output | 1 | Word matched no encoding |

## Verification
Single-word vectors are drawn from each field-compression family, at the edges of each range: the lowest and highest mapped registers, all-ones immediates, and negative and positive relative offsets. A wrong shift or a wrong base register therefore shows up as a different index. Two-word vectors use second words of 0x0000 and 0xFFFF and a gap of idle cycles. These tell a correct fold apart from one that decodes the second word by itself or loses the held first word. Fixed encodings are paired with one-bit neighbours that must come out illegal. An illegal word followed at once by a normal word, and a reset between the two words of a long jump, show whether a held state leaks into the next decode.

// File: rtl/insn_word_decoder.sv
module insn_word_decoder #(
  parameter int WORD_W = 16,
  parameter int IMM_W  = 22,
  parameter int OP_W   = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_word,
  output logic              out_valid,
  output logic [OP_W-1:0]   out_op,
  output logic [4:0]        out_rd,
  output logic [4:0]        out_rr,
  output logic [IMM_W-1:0]  out_imm,
  output logic [2:0]        out_bit,
  output logic              out_illegal
);

  typedef enum logic [OP_W-1:0] {
    OP_NOP = 7'd0, OP_ADD = 7'd1, OP_LDI = 7'd2, OP_ADIW = 7'd3, OP_MOVW = 7'd4,
    OP_MULS = 7'd5, OP_FMULSU = 7'd6, OP_JMP = 7'd7, OP_CALL = 7'd8, OP_LDS = 7'd9,
    OP_STS = 7'd10, OP_LDD_Y = 7'd11, OP_LDD_Z = 7'd12, OP_STD_Y = 7'd13,
    OP_STD_Z = 7'd14, OP_RJMP = 7'd15, OP_BRBS = 7'd16, OP_RET = 7'd17,
    OP_RETI = 7'd18, OP_IJMP = 7'd19, OP_SLEEP = 7'd20, OP_SUBI = 7'd21,
    OP_SBIW = 7'd22, OP_FMUL = 7'd23, OP_MULSU = 7'd24, OP_FMULS = 7'd25,
    OP_RCALL, OP_BRBC, OP_ADC, OP_SUB, OP_SBC, OP_SBCI, OP_AND, OP_ANDI, OP_OR,
    OP_ORI, OP_EOR, OP_COM, OP_NEG, OP_INC, OP_DEC, OP_MUL, OP_DES, OP_EIJMP,
    OP_ICALL, OP_EICALL, OP_CPSE, OP_CP, OP_CPC, OP_CPI, OP_SBRC, OP_SBRS,
    OP_SBIC, OP_SBIS, OP_MOV, OP_LD_X, OP_LD_XI, OP_LD_XD, OP_LD_YI, OP_LD_YD,
    OP_LD_ZI, OP_LD_ZD, OP_ST_X, OP_ST_XI, OP_ST_XD, OP_ST_YI, OP_ST_YD,
    OP_ST_ZI, OP_ST_ZD, OP_LPM, OP_LPM_R, OP_LPM_RI, OP_ELPM, OP_ELPM_R,
    OP_ELPM_RI, OP_SPM, OP_SPM_ZI, OP_IN, OP_OUT, OP_PUSH, OP_POP, OP_XCH,
    OP_LAC, OP_LAS, OP_LAT, OP_LSR, OP_ROR, OP_ASR, OP_SWAP, OP_SBI, OP_CBI,
    OP_BST, OP_BLD, OP_BSET, OP_BCLR, OP_BREAK, OP_WDR
  } op_e;

  logic              pending_q;
  logic [WORD_W-1:0] first_q;
  logic [WORD_W-1:0] w;
  logic              beat;

  op_e               d_op;
  logic [4:0]        d_rd, d_rr;
  logic [IMM_W-1:0]  d_imm;
  logic [2:0]        d_bit;
  logic              d_two, d_ill;

  assign in_ready = !rst;
  assign beat     = in_valid && in_ready;
  assign w        = pending_q ? first_q : in_word;

  wire [4:0]       f_rd  = w[8:4];
  wire [4:0]       f_rr  = {w[9], w[3:0]};
  wire [4:0]       f_hd  = {1'b1, w[7:4]};
  wire [4:0]       f_hr  = {1'b1, w[3:0]};
  wire [4:0]       f_md  = {2'b10, w[6:4]};
  wire [4:0]       f_mr  = {2'b10, w[2:0]};
  wire [IMM_W-1:0] f_k8  = {{(IMM_W-8){1'b0}}, w[11:8], w[3:0]};
  wire [IMM_W-1:0] f_k6  = {{(IMM_W-6){1'b0}}, w[7:6], w[3:0]};
  wire [IMM_W-1:0] f_q6  = {{(IMM_W-6){1'b0}}, w[13], w[11:10], w[2:0]};
  wire [IMM_W-1:0] f_io6 = {{(IMM_W-6){1'b0}}, w[10:9], w[3:0]};
  wire [IMM_W-1:0] f_io5 = {{(IMM_W-5){1'b0}}, w[7:3]};
  wire [IMM_W-1:0] f_s12 = {{(IMM_W-12){w[11]}}, w[11:0]};
  wire [IMM_W-1:0] f_s7  = {{(IMM_W-7){w[9]}}, w[9:3]};
  wire [IMM_W-1:0] f_far = {w[8:4], w[0], in_word};
  wire [IMM_W-1:0] f_abs = {{(IMM_W-WORD_W){1'b0}}, in_word};

  always_comb begin
    d_op = OP_NOP; d_rd = '0; d_rr = '0; d_imm = '0; d_bit = '0;
    d_two = 1'b0; d_ill = 1'b0;
    casez (w)
      16'h0000: d_op = OP_NOP;
      16'h9409: d_op = OP_IJMP;
      16'h9419: d_op = OP_EIJMP;
      16'h9509: d_op = OP_ICALL;
      16'h9519: d_op = OP_EICALL;
      16'h9508: d_op = OP_RET;
      16'h9518: d_op = OP_RETI;
      16'h95C8: d_op = OP_LPM;
      16'h95D8: d_op = OP_ELPM;
      16'h95E8: d_op = OP_SPM;
      16'h95F8: d_op = OP_SPM_ZI;
      16'h9598: d_op = OP_BREAK;
      16'h9588: d_op = OP_SLEEP;
      16'h95A8: d_op = OP_WDR;
      16'b1001_0100_0???_1000: begin d_op = OP_BSET; d_bit = w[6:4]; end
      16'b1001_0100_1???_1000: begin d_op = OP_BCLR; d_bit = w[6:4]; end
      16'b1001_0100_????_1011: begin d_op = OP_DES; d_imm = {{(IMM_W-4){1'b0}}, w[7:4]}; end
      16'b1001_010?_????_110?: begin d_op = OP_JMP;  d_imm = f_far; d_two = 1'b1; end
      16'b1001_010?_????_111?: begin d_op = OP_CALL; d_imm = f_far; d_two = 1'b1; end
      16'b1001_010?_????_0000: begin d_op = OP_COM;  d_rd = f_rd; end
      16'b1001_010?_????_0001: begin d_op = OP_NEG;  d_rd = f_rd; end
      16'b1001_010?_????_0010: begin d_op = OP_SWAP; d_rd = f_rd; end
      16'b1001_010?_????_0011: begin d_op = OP_INC;  d_rd = f_rd; end
      16'b1001_010?_????_0101: begin d_op = OP_ASR;  d_rd = f_rd; end
      16'b1001_010?_????_0110: begin d_op = OP_LSR;  d_rd = f_rd; end
      16'b1001_010?_????_0111: begin d_op = OP_ROR;  d_rd = f_rd; end
      16'b1001_010?_????_1010: begin d_op = OP_DEC;  d_rd = f_rd; end
      16'b1001_000?_????_0000: begin d_op = OP_LDS; d_rd = f_rd; d_imm = f_abs; d_two = 1'b1; end
      16'b1001_001?_????_0000: begin d_op = OP_STS; d_rd = f_rd; d_imm = f_abs; d_two = 1'b1; end
      16'b1001_000?_????_0001: begin d_op = OP_LD_ZI;   d_rd = f_rd; end
      16'b1001_000?_????_0010: begin d_op = OP_LD_ZD;   d_rd = f_rd; end
      16'b1001_000?_????_0100: begin d_op = OP_LPM_R;   d_rd = f_rd; end
      16'b1001_000?_????_0101: begin d_op = OP_LPM_RI;  d_rd = f_rd; end
      16'b1001_000?_????_0110: begin d_op = OP_ELPM_R;  d_rd = f_rd; end
      16'b1001_000?_????_0111: begin d_op = OP_ELPM_RI; d_rd = f_rd; end
      16'b1001_000?_????_1001: begin d_op = OP_LD_YI;   d_rd = f_rd; end
      16'b1001_000?_????_1010: begin d_op = OP_LD_YD;   d_rd = f_rd; end
      16'b1001_000?_????_1100: begin d_op = OP_LD_X;    d_rd = f_rd; end
      16'b1001_000?_????_1101: begin d_op = OP_LD_XI;   d_rd = f_rd; end
      16'b1001_000?_????_1110: begin d_op = OP_LD_XD;   d_rd = f_rd; end
      16'b1001_000?_????_1111: begin d_op = OP_POP;     d_rd = f_rd; end
      16'b1001_001?_????_0001: begin d_op = OP_ST_ZI;   d_rd = f_rd; end
      16'b1001_001?_????_0010: begin d_op = OP_ST_ZD;   d_rd = f_rd; end
      16'b1001_001?_????_0100: begin d_op = OP_XCH;     d_rd = f_rd; end
      16'b1001_001?_????_0101: begin d_op = OP_LAS;     d_rd = f_rd; end
      16'b1001_001?_????_0110: begin d_op = OP_LAC;     d_rd = f_rd; end
      16'b1001_001?_????_0111: begin d_op = OP_LAT;     d_rd = f_rd; end
      16'b1001_001?_????_1001: begin d_op = OP_ST_YI;   d_rd = f_rd; end
      16'b1001_001?_????_1010: begin d_op = OP_ST_YD;   d_rd = f_rd; end
      16'b1001_001?_????_1100: begin d_op = OP_ST_X;    d_rd = f_rd; end
      16'b1001_001?_????_1101: begin d_op = OP_ST_XI;   d_rd = f_rd; end
      16'b1001_001?_????_1110: begin d_op = OP_ST_XD;   d_rd = f_rd; end
      16'b1001_001?_????_1111: begin d_op = OP_PUSH;    d_rd = f_rd; end
      16'b1001_0110_????_????: begin d_op = OP_ADIW; d_rd = {2'b11, w[5:4], 1'b0}; d_imm = f_k6; end
      16'b1001_0111_????_????: begin d_op = OP_SBIW; d_rd = {2'b11, w[5:4], 1'b0}; d_imm = f_k6; end
      16'b1001_1000_????_????: begin d_op = OP_CBI;  d_imm = f_io5; d_bit = w[2:0]; end
      16'b1001_1001_????_????: begin d_op = OP_SBIC; d_imm = f_io5; d_bit = w[2:0]; end
      16'b1001_1010_????_????: begin d_op = OP_SBI;  d_imm = f_io5; d_bit = w[2:0]; end
      16'b1001_1011_????_????: begin d_op = OP_SBIS; d_imm = f_io5; d_bit = w[2:0]; end
      16'b1001_11??_????_????: begin d_op = OP_MUL; d_rd = f_rd; d_rr = f_rr; end
      16'b0000_0001_????_????: begin d_op = OP_MOVW; d_rd = {w[7:4], 1'b0}; d_rr = {w[3:0], 1'b0}; end
      16'b0000_0010_????_????: begin d_op = OP_MULS; d_rd = f_hd; d_rr = f_hr; end
      16'b0000_0011_0???_0???: begin d_op = OP_MULSU;  d_rd = f_md; d_rr = f_mr; end
      16'b0000_0011_0???_1???: begin d_op = OP_FMUL;   d_rd = f_md; d_rr = f_mr; end
      16'b0000_0011_1???_0???: begin d_op = OP_FMULS;  d_rd = f_md; d_rr = f_mr; end
      16'b0000_0011_1???_1???: begin d_op = OP_FMULSU; d_rd = f_md; d_rr = f_mr; end
      16'b0000_01??_????_????: begin d_op = OP_CPC;  d_rd = f_rd; d_rr = f_rr; end
      16'b0000_10??_????_????: begin d_op = OP_SBC;  d_rd = f_rd; d_rr = f_rr; end
      16'b0000_11??_????_????: begin d_op = OP_ADD;  d_rd = f_rd; d_rr = f_rr; end
      16'b0001_00??_????_????: begin d_op = OP_CPSE; d_rd = f_rd; d_rr = f_rr; end
      16'b0001_01??_????_????: begin d_op = OP_CP;   d_rd = f_rd; d_rr = f_rr; end
      16'b0001_10??_????_????: begin d_op = OP_SUB;  d_rd = f_rd; d_rr = f_rr; end
      16'b0001_11??_????_????: begin d_op = OP_ADC;  d_rd = f_rd; d_rr = f_rr; end
      16'b0010_00??_????_????: begin d_op = OP_AND;  d_rd = f_rd; d_rr = f_rr; end
      16'b0010_01??_????_????: begin d_op = OP_EOR;  d_rd = f_rd; d_rr = f_rr; end
      16'b0010_10??_????_????: begin d_op = OP_OR;   d_rd = f_rd; d_rr = f_rr; end
      16'b0010_11??_????_????: begin d_op = OP_MOV;  d_rd = f_rd; d_rr = f_rr; end
      16'b0011_????_????_????: begin d_op = OP_CPI;  d_rd = f_hd; d_imm = f_k8; end
      16'b0100_????_????_????: begin d_op = OP_SBCI; d_rd = f_hd; d_imm = f_k8; end
      16'b0101_????_????_????: begin d_op = OP_SUBI; d_rd = f_hd; d_imm = f_k8; end
      16'b0110_????_????_????: begin d_op = OP_ORI;  d_rd = f_hd; d_imm = f_k8; end
      16'b0111_????_????_????: begin d_op = OP_ANDI; d_rd = f_hd; d_imm = f_k8; end
      16'b1110_????_????_????: begin d_op = OP_LDI;  d_rd = f_hd; d_imm = f_k8; end
      16'b10?0_??0?_????_1???: begin d_op = OP_LDD_Y; d_rd = f_rd; d_imm = f_q6; end
      16'b10?0_??0?_????_0???: begin d_op = OP_LDD_Z; d_rd = f_rd; d_imm = f_q6; end
      16'b10?0_??1?_????_1???: begin d_op = OP_STD_Y; d_rd = f_rd; d_imm = f_q6; end
      16'b10?0_??1?_????_0???: begin d_op = OP_STD_Z; d_rd = f_rd; d_imm = f_q6; end
      16'b1011_0???_????_????: begin d_op = OP_IN;  d_rd = f_rd; d_imm = f_io6; end
      16'b1011_1???_????_????: begin d_op = OP_OUT; d_rd = f_rd; d_imm = f_io6; end
      16'b1100_????_????_????: begin d_op = OP_RJMP;  d_imm = f_s12; end
      16'b1101_????_????_????: begin d_op = OP_RCALL; d_imm = f_s12; end
      16'b1111_00??_????_????: begin d_op = OP_BRBS; d_imm = f_s7; d_bit = w[2:0]; end
      16'b1111_01??_????_????: begin d_op = OP_BRBC; d_imm = f_s7; d_bit = w[2:0]; end
      16'b1111_100?_????_0???: begin d_op = OP_BLD;  d_rd = f_rd; d_bit = w[2:0]; end
      16'b1111_101?_????_0???: begin d_op = OP_BST;  d_rd = f_rd; d_bit = w[2:0]; end
      16'b1111_110?_????_0???: begin d_op = OP_SBRC; d_rd = f_rd; d_bit = w[2:0]; end
      16'b1111_111?_????_0???: begin d_op = OP_SBRS; d_rd = f_rd; d_bit = w[2:0]; end
      default: d_ill = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pending_q   <= 1'b0;
      first_q     <= '0;
      out_valid   <= 1'b0;
      out_op      <= '0;
      out_rd      <= '0;
      out_rr      <= '0;
      out_imm     <= '0;
      out_bit     <= '0;
      out_illegal <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      if (beat) begin
        if (!pending_q && d_two) begin
          pending_q <= 1'b1;
          first_q   <= in_word;
        end else begin
          pending_q   <= 1'b0;
          out_valid   <= 1'b1;
          out_op      <= d_op;
          out_rd      <= d_rd;
          out_rr      <= d_rr;
          out_imm     <= d_imm;
          out_bit     <= d_bit;
          out_illegal <= d_ill;
        end
      end
    end
  end

  p_wait_silent_r10: assert property (@(posedge clk) disable iff (rst)
    pending_q |-> !out_valid);

  p_hold_first_r10: assert property (@(posedge clk) disable iff (rst)
    (pending_q && !in_valid) |=> (pending_q && $stable(first_q)));

  p_fold_one_out_r8: assert property (@(posedge clk) disable iff (rst)
    (pending_q && in_valid) |=> (out_valid && !pending_q));

  p_illegal_no_start_r14: assert property (@(posedge clk) disable iff (rst)
    (beat && !pending_q && d_ill) |=> (!pending_q && out_valid && out_illegal));

  p_illegal_is_nop_r14: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_illegal) |-> (out_op == '0 && out_imm == '0 && out_rd == '0));

  p_out_after_beat_r2: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid));

endmodule

// File: tb/insn_word_decoder_bench.sv
module insn_word_decoder_bench;
  localparam time CLK_PERIOD = 10ns;

  typedef struct packed {
    logic [6:0]  op;
    logic [4:0]  rd;
    logic [4:0]  rr;
    logic [21:0] imm;
    logic [2:0]  bitx;
    logic        ill;
  } res_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [15:0] in_word = '0;
  logic        in_ready, out_valid, out_illegal;
  logic [6:0]  out_op;
  logic [4:0]  out_rd, out_rr;
  logic [21:0] out_imm;
  logic [2:0]  out_bit;

  int n_chk = 0;
  int n_bad = 0;
  res_t  exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  insn_word_decoder u_insn_word_decoder (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .out_valid(out_valid), .out_op(out_op),
    .out_rd(out_rd), .out_rr(out_rr), .out_imm(out_imm),
    .out_bit(out_bit), .out_illegal(out_illegal)
  );

  task automatic check1(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic expect_res(input string tag, input int op, input int rd, input int rr,
                            input int imm, input int bitx, input bit ill);
    res_t r;
    r.op = op[6:0]; r.rd = rd[4:0]; r.rr = rr[4:0];
    r.imm = imm[21:0]; r.bitx = bitx[2:0]; r.ill = ill;
    exp_q.push_back(r);
    tag_q.push_back(tag);
  endtask

  task automatic put(input logic [15:0] wd);
    in_valid = 1'b1;
    in_word  = wd;
    @(negedge clk);
    in_valid = 1'b0;
    in_word  = 16'hxxxx;
  endtask

  task automatic idle_quiet(input string tag, input int n);
    for (int i = 0; i < n; i++) begin
      check1(tag, {63'd0, out_valid}, 64'd0);
      @(negedge clk);
    end
  endtask

  always @(negedge clk) begin
    if (out_valid) begin
      res_t got;
      got = {out_op, out_rd, out_rr, out_imm, out_bit, out_illegal};
      n_chk++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL R2: unexpected result actual %0h expected none", got);
      end else begin
        res_t want;
        string t;
        want = exp_q.pop_front();
        t = tag_q.pop_front();
        if (got !== want) begin
          n_bad++;
          $display("FAIL %s: actual op=%0d rd=%0d rr=%0d imm=%0h bit=%0d ill=%0b expected op=%0d rd=%0d rr=%0d imm=%0h bit=%0d ill=%0b",
                   t, got.op, got.rd, got.rr, got.imm, got.bitx, got.ill,
                   want.op, want.rd, want.rr, want.imm, want.bitx, want.ill);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check1("R1 ready low in reset", {63'd0, in_ready}, 64'd0);
    check1("R1 valid low in reset", {63'd0, out_valid}, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    check1("R1 ready after reset", {63'd0, in_ready}, 64'd1);
    check1("R1 valid after reset", {63'd0, out_valid}, 64'd0);

    expect_res("R3 ADD r5,r17", 1, 5, 17, 0, 0, 0);      put(16'h0E51);
    expect_res("R4 LDI r20", 2, 20, 0, 'hA7, 0, 0);      put(16'hEA47);
    expect_res("R4 SUBI r31", 21, 31, 0, 'h0F, 0, 0);    put(16'h50FF);
    expect_res("R5 ADIW r30", 3, 30, 0, 63, 0, 0);       put(16'h96FF);
    expect_res("R5 SBIW r24", 22, 24, 0, 5, 0, 0);       put(16'h9705);
    expect_res("R6 MOVW r6,r30", 4, 6, 30, 0, 0, 0);     put(16'h013F);
    expect_res("R6 MULS r16,r31", 5, 16, 31, 0, 0, 0);   put(16'h020F);
    expect_res("R7 MULSU r17,r23", 24, 17, 23, 0, 0, 0); put(16'h0317);
    expect_res("R7 FMULSU r23,r16", 6, 23, 16, 0, 0, 0); put(16'h03F8);
    expect_res("R7 FMUL r18,r19", 23, 18, 19, 0, 0, 0);  put(16'h032B);
    expect_res("R7 FMULS r20,r21", 25, 20, 21, 0, 0, 0); put(16'h03C5);

    expect_res("R8 JMP far", 7, 0, 0, 'h2D1234, 0, 0);
    put(16'h956D); put(16'h1234);
    expect_res("R8 R10 CALL after gap", 8, 0, 0, 'h00FFFF, 0, 0);
    put(16'h940E);
    idle_quiet("R10 no output while waiting", 3);
    put(16'hFFFF);

    expect_res("R9 LDS r9", 9, 9, 0, 'hBEEF, 0, 0);
    put(16'h9090); put(16'hBEEF);
    expect_res("R9 STS r31 zero second word", 10, 31, 0, 0, 0, 0);
    put(16'h93F0); put(16'h0000);

    expect_res("R11 LDD Y q63", 11, 3, 0, 63, 0, 0);     put(16'hAC3F);
    expect_res("R11 STD Z q34", 14, 20, 0, 34, 0, 0);    put(16'hA342);
    expect_res("R11 LDD Z q0", 12, 0, 0, 0, 0, 0);       put(16'h8000);

    expect_res("R12 RJMP -1", 15, 0, 0, 'h3FFFFF, 0, 0); put(16'hCFFF);
    expect_res("R12 RJMP +2047", 15, 0, 0, 'h7FF, 0, 0); put(16'hC7FF);
    expect_res("R12 BRBS -64 bit5", 16, 0, 0, 'h3FFFC0, 5, 0); put(16'hF205);

    expect_res("R13 NOP", 0, 0, 0, 0, 0, 0);             put(16'h0000);
    expect_res("R13 RET", 17, 0, 0, 0, 0, 0);            put(16'h9508);
    expect_res("R13 RETI", 18, 0, 0, 0, 0, 0);           put(16'h9518);
    expect_res("R13 IJMP", 19, 0, 0, 0, 0, 0);           put(16'h9409);
    expect_res("R13 SLEEP", 20, 0, 0, 0, 0, 0);          put(16'h9588);
    expect_res("R13 near miss illegal", 0, 0, 0, 0, 0, 1); put(16'h9528);
    expect_res("R14 0x0001 illegal", 0, 0, 0, 0, 0, 1);  put(16'h0001);

    expect_res("R14 0xFFFF illegal", 0, 0, 0, 0, 0, 1);  put(16'hFFFF);
    expect_res("R14 next word stands alone", 1, 5, 17, 0, 0, 0); put(16'h0E51);

    put(16'h956D);
    rst = 1'b1;
    @(negedge clk);
    check1("R1 reset drops pending output", {63'd0, out_valid}, 64'd0);
    rst = 1'b0;
    expect_res("R1 fresh decode after reset", 1, 5, 17, 0, 0, 0);
    put(16'h0E51);

    repeat (3) @(negedge clk);
    check1("R2 all expected results seen", 64'(exp_q.size()), 64'd0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule